// File: doc/BRIEF.md
# DDR Write Strobe Sequencer

This block sits on the controller side of a DDR memory interface. It turns write commands from a user port into the timed strobe, data and mask drive for the write burst. Each command carries four data beats and four per-beat mask bits. The sequencer waits a fixed write latency after it accepts the command. It then drives the strobe out of high impedance with a low preamble. It sends the four beats on the two edges of two strobe periods and finishes with a low postamble before it releases the strobe again. When a second command arrives so that its beats directly follow the first burst, the strobe stays driven and toggling, with no postamble or preamble between the bursts.

The pad-side outputs are modelled per clock cycle as two half-cycle slots: bit 0 of every two-bit output is the first (clock-high) half and bit 1 is the second half. The strobe has its own per-half output enable. The data and mask lanes carry an enable and a flag that tells the I/O stage to launch them a quarter cycle after the strobe edges, so that data sits centred in the strobe eye. `WR_LAT` sets the write latency in whole clocks and must be at least 1.

Top module: `ddr_wstrobe_seq`

## Requirements
- R1: After reset `cmd_ready` is 1 and `dqs_oe`, `dq_oe`, `dm_o` and `dq_qshift` are all 0.
- R2: A command accepted at rising edge k (`cmd_valid` and `cmd_ready` both high) has its first data cycle in the clock cycle that begins at edge k+`WR_LAT`, and the second data cycle directly after it.
- R3: The clock cycle before a burst's first data cycle, when it is not itself a data cycle, drives the strobe low for both halves (`dqs_oe`=11, `dqs_o`=00). With no burst activity the strobe is undriven (`dqs_oe`=00), and the strobe never leaves high impedance at a high level.
- R4: In every data cycle `dqs_oe`=11 and `dqs_o`=01: high in the first half and low in the second half, so each data cycle has one rising and one falling strobe edge.
- R5: Beat i of a command is `cmd_data[i*DQ_W +: DQ_W]`. The first data cycle carries beat 0 in `dq_o[DQ_W-1:0]` (first half) and beat 1 in the upper half. The second data cycle carries beats 2 and 3 in the same way.
- R6: `cmd_mask[i]`=1 marks beat i as masked. `dm_o` bit 0/1 carries the mask of the beat in the first/second half of each data cycle, and `dm_o` is 00 outside data cycles.
- R7: The cycle after a burst's last data cycle, when no data or preamble follows, drives the strobe low for the first half only (`dqs_oe`=01, `dqs_o`=00). The strobe is then undriven.
- R8: `cmd_ready` is 0 for exactly the one cycle after an acceptance and 1 otherwise. A command offered while `cmd_ready` is 0 is not taken and produces no burst.
- R9: Commands accepted two edges apart give four consecutive data cycles with the strobe driven and toggling throughout, with no preamble or postamble between them.
- R10: Commands accepted three edges apart give one full driven-low cycle (`dqs_oe`=11, `dqs_o`=00) between the two bursts, which joins the postamble and the preamble.
- R11: `dq_oe`=11 and `dq_qshift`=1 exactly in data cycles. Outside them `dq_oe`=00, `dq_qshift`=0 and `dq_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Write command offered |
| cmd_ready | output | 1 | Sequencer can take a command this cycle |
| cmd_data | input | 4*DQ_W | Four write beats, beat 0 in the low bits |
| cmd_mask | input | 4 | Per-beat mask, 1 = do not write |
| dqs_oe | output | 2 | Strobe drive enable per half cycle |
| dqs_o | output | 2 | Strobe level per half cycle |
| dq_oe | output | 2 | Data lane drive enable per half cycle |
| dq_o | output | 2*DQ_W | Data per half cycle, first half in the low bits |
| dm_o | output | 2 | Mask lane per half cycle |
| dq_qshift | output | 1 | Launch data and mask a quarter cycle after the strobe edges |

## Verification
The hardest situations to reach from the ports are the seams between bursts. A burst that continues the previous one needs a command taken on the very cycle that `cmd_ready` comes back. The merged low cycle needs a command taken exactly one cycle later than that. The stimulus holds each command valid until it is taken and sweeps the idle gap before the next offer from zero to five cycles, across all sixteen mask patterns. A zero gap also lands an offer in the refused cycle. The bench then derives the expected strobe for every cycle from where the data cycles fall and compares the whole recorded trace.

// File: rtl/ddrws_pkg.sv
package ddrws_pkg;

    // Burst geometry: beats per burst and beats carried by one clock cycle
    localparam int BURST_BEATS   = 4;
    localparam int BEATS_PER_CLK = 2;
    localparam int DATA_SLOTS    = BURST_BEATS / BEATS_PER_CLK;
    // Role timeline: slot 0 preamble, slots 1..DATA_SLOTS data, last postamble
    localparam int SLOTS         = DATA_SLOTS + 2;

    // Per-half-cycle strobe drive; bit 0 is the first half of the cycle
    typedef struct packed {
        logic [BEATS_PER_CLK-1:0] oe;
        logic [BEATS_PER_CLK-1:0] lvl;
    } strobe_t;

    // Strobe shape for a cycle given every burst role that lands on it.
    // Data beats take priority, then the preamble, then the postamble.
    function automatic strobe_t strobe_for(input logic [SLOTS-1:0] roles);
        strobe_t s;
        if (|roles[SLOTS-2:1]) begin
            s.oe  = 2'b11;
            s.lvl = 2'b01;
        end else if (roles[0]) begin
            s.oe  = 2'b11;
            s.lvl = 2'b00;
        end else if (roles[SLOTS-1]) begin
            s.oe  = 2'b01;
            s.lvl = 2'b00;
        end else begin
            s.oe  = 2'b00;
            s.lvl = 2'b00;
        end
        return s;
    endfunction

endpackage

// File: rtl/ddrws_admit.sv
module ddrws_admit (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    output logic cmd_ready,
    output logic take
);

    typedef struct packed {
        logic took;
    } adm_t;

    adm_t adm_d, adm_q;

    // A burst needs two clocks of data; refuse the cycle right after a take
    assign cmd_ready = ~adm_q.took;
    assign take      = cmd_valid & cmd_ready;

    always_comb begin
        adm_d      = adm_q;
        adm_d.took = take;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) adm_q <= '0;
        else        adm_q <= adm_d;
    end

endmodule

// File: rtl/ddrws_launch_delay.sv
module ddrws_launch_delay #(
    parameter int PAY_W = 68,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [PAY_W-1:0] in_pay,
    output logic             out_vld,
    output logic [PAY_W-1:0] out_pay
);

    typedef struct packed {
        logic             vld;
        logic [PAY_W-1:0] pay;
    } stage_t;

    stage_t [DEPTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0].vld = in_vld;
        pipe_d[0].pay = in_pay;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_vld = pipe_q[DEPTH-1].vld;
    assign out_pay = pipe_q[DEPTH-1].pay;

endmodule

// File: rtl/ddrws_timeline.sv
module ddrws_timeline
    import ddrws_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [BURST_BEATS*DQ_W-1:0]    start_dq,
    input  logic [BURST_BEATS-1:0]         start_dm,
    output logic [SLOTS-1:0]               roles_nxt,
    output logic [BEATS_PER_CLK*DQ_W-1:0]  beats_nxt,
    output logic [BEATS_PER_CLK-1:0]       dm_nxt
);

    localparam int BURST_W = BURST_BEATS * DQ_W;
    localparam int PAIR_W  = BEATS_PER_CLK * DQ_W;

    // hist holds the roles of the current cycle except the postamble slot,
    // which only ever shifts out
    typedef struct packed {
        logic [SLOTS-2:0]       hist;
        logic [BURST_W-1:0]     dq;
        logic [BURST_BEATS-1:0] dm;
    } tl_t;

    tl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        roles_nxt = {st_q.hist, start};
        st_d.hist = roles_nxt[SLOTS-2:0];
        if (start) begin
            st_d.dq = start_dq;
            st_d.dm = start_dm;
        end
        // Beats for next cycle come from the stored burst; a new burst
        // arriving now is only written at this edge, so the old one is read
        beats_nxt = '0;
        dm_nxt    = '0;
        for (int s = 0; s < DATA_SLOTS; s++) begin
            if (roles_nxt[s+1]) begin
                beats_nxt = st_q.dq[s*PAIR_W +: PAIR_W];
                dm_nxt    = st_q.dm[s*BEATS_PER_CLK +: BEATS_PER_CLK];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ddrws_pin_stage.sv
module ddrws_pin_stage
    import ddrws_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SLOTS-1:0]              roles_nxt,
    input  logic [BEATS_PER_CLK*DQ_W-1:0] beats_nxt,
    input  logic [BEATS_PER_CLK-1:0]      dm_nxt,
    output logic [BEATS_PER_CLK-1:0]      dqs_oe,
    output logic [BEATS_PER_CLK-1:0]      dqs_o,
    output logic [BEATS_PER_CLK-1:0]      dq_oe,
    output logic [BEATS_PER_CLK*DQ_W-1:0] dq_o,
    output logic [BEATS_PER_CLK-1:0]      dm_o,
    output logic                          dq_qshift
);

    localparam int PAIR_W = BEATS_PER_CLK * DQ_W;

    typedef struct packed {
        strobe_t                  stb;
        logic [BEATS_PER_CLK-1:0] dq_en;
        logic [PAIR_W-1:0]        dq;
        logic [BEATS_PER_CLK-1:0] dm;
        logic                     qshift;
    } pin_t;

    pin_t pin_d, pin_q;
    logic any_data;

    always_comb begin
        any_data     = |roles_nxt[SLOTS-2:1];
        pin_d.stb    = strobe_for(roles_nxt);
        pin_d.dq_en  = {BEATS_PER_CLK{any_data}};
        pin_d.dq     = beats_nxt;
        pin_d.dm     = dm_nxt;
        pin_d.qshift = any_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_d;
    end

    assign dqs_oe    = pin_q.stb.oe;
    assign dqs_o     = pin_q.stb.lvl;
    assign dq_oe     = pin_q.dq_en;
    assign dq_o      = pin_q.dq;
    assign dm_o      = pin_q.dm;
    assign dq_qshift = pin_q.qshift;

endmodule

// File: rtl/ddr_wstrobe_seq.sv
module ddr_wstrobe_seq
    import ddrws_pkg::*;
#(
    parameter int DQ_W   = 16,
    parameter int WR_LAT = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    output logic                          cmd_ready,
    input  logic [BURST_BEATS*DQ_W-1:0]   cmd_data,
    input  logic [BURST_BEATS-1:0]        cmd_mask,
    output logic [BEATS_PER_CLK-1:0]      dqs_oe,
    output logic [BEATS_PER_CLK-1:0]      dqs_o,
    output logic [BEATS_PER_CLK-1:0]      dq_oe,
    output logic [BEATS_PER_CLK*DQ_W-1:0] dq_o,
    output logic [BEATS_PER_CLK-1:0]      dm_o,
    output logic                          dq_qshift
);

    localparam int BURST_W      = BURST_BEATS * DQ_W;
    localparam int PAY_W        = BURST_W + BURST_BEATS;
    localparam int LAUNCH_DEPTH = WR_LAT - 1;
    localparam int PAIR_W       = BEATS_PER_CLK * DQ_W;

    logic                     take;
    logic                     go;
    logic [PAY_W-1:0]         go_pay;
    logic [SLOTS-1:0]         roles_nxt;
    logic [PAIR_W-1:0]        beats_nxt;
    logic [BEATS_PER_CLK-1:0] dm_nxt;

    ddrws_admit u_admit (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .take      (take)
    );

    // Latency beyond the one preamble clock is a payload delay line
    generate
        if (LAUNCH_DEPTH > 0) begin : g_delay
            ddrws_launch_delay #(
                .PAY_W (PAY_W),
                .DEPTH (LAUNCH_DEPTH)
            ) u_delay (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_vld  (take),
                .in_pay  ({cmd_mask, cmd_data}),
                .out_vld (go),
                .out_pay (go_pay)
            );
        end else begin : g_direct
            assign go     = take;
            assign go_pay = {cmd_mask, cmd_data};
        end
    endgenerate

    ddrws_timeline #(
        .DQ_W (DQ_W)
    ) u_timeline (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (go),
        .start_dq  (go_pay[BURST_W-1:0]),
        .start_dm  (go_pay[PAY_W-1:BURST_W]),
        .roles_nxt (roles_nxt),
        .beats_nxt (beats_nxt),
        .dm_nxt    (dm_nxt)
    );

    ddrws_pin_stage #(
        .DQ_W (DQ_W)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .roles_nxt (roles_nxt),
        .beats_nxt (beats_nxt),
        .dm_nxt    (dm_nxt),
        .dqs_oe    (dqs_oe),
        .dqs_o     (dqs_o),
        .dq_oe     (dq_oe),
        .dq_o      (dq_o),
        .dm_o      (dm_o),
        .dq_qshift (dq_qshift)
    );

endmodule

// File: rtl/ddrws_checker.sv
module ddrws_checker #(
    parameter int DQ_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic [1:0]      dqs_oe,
    input logic [1:0]      dqs_o,
    input logic [1:0]      dq_oe,
    input logic [2*DQ_W-1:0] dq_o,
    input logic [1:0]      dm_o,
    input logic            dq_qshift
);

    assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_ready_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> cmd_ready);

    assert_leave_hiz_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dqs_oe) == 2'b00 && dqs_oe != 2'b00) |-> (dqs_oe == 2'b11 && dqs_o == 2'b00));

    assert_level_needs_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dqs_o & ~dqs_oe) == 2'b00);

    assert_data_under_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe != 2'b00) |-> (dqs_oe == 2'b11 && dqs_o == 2'b01 && dq_qshift));

    assert_postamble_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dq_oe) == 2'b11 && dq_oe == 2'b00) |-> (dqs_oe[0] && dqs_o == 2'b00));

    assert_release_after_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dqs_oe) != 2'b00 && dqs_oe == 2'b00) |-> ($past(dqs_oe) == 2'b01));

    assert_lanes_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe == 2'b00) |-> (dq_o == '0 && dm_o == 2'b00 && !dq_qshift));

endmodule

bind ddr_wstrobe_seq ddrws_checker #(.DQ_W(DQ_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .dqs_oe    (dqs_oe),
    .dqs_o     (dqs_o),
    .dq_oe     (dq_oe),
    .dq_o      (dq_o),
    .dm_o      (dm_o),
    .dq_qshift (dq_qshift)
);

// File: tb/sim_ddr_wstrobe_seq.sv
module sim_ddr_wstrobe_seq;

    localparam int DW    = 16;
    localparam int LAT   = 2;
    localparam int NC    = 2048;
    localparam int LIMIT = 150000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic            cmd_ready;
    logic [4*DW-1:0] cmd_data = '0;
    logic [3:0]      cmd_mask = '0;
    logic [1:0]      dqs_oe, dqs_o, dq_oe, dm_o;
    logic [2*DW-1:0] dq_o;
    logic            dq_qshift;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int last_acc = -100;
    int n_acc = 0;
    bit done = 1'b0;

    logic [3:0]      a_stb [NC];
    logic [1:0]      a_dqe [NC];
    logic            a_qs  [NC];
    logic [2*DW-1:0] a_dq  [NC];
    logic [1:0]      a_dm  [NC];
    logic            e_dat [NC];
    logic [2*DW-1:0] e_dq  [NC];
    logic [1:0]      e_dm  [NC];
    int              acc_edge [256];
    logic [DW-1:0]   acc_b0   [256];

    always #2 clk = ~clk;

    ddr_wstrobe_seq #(.DQ_W(DW), .WR_LAT(LAT)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_data  (cmd_data),
        .cmd_mask  (cmd_mask),
        .dqs_oe    (dqs_oe),
        .dqs_o     (dqs_o),
        .dq_oe     (dq_oe),
        .dq_o      (dq_o),
        .dm_o      (dm_o),
        .dq_qshift (dq_qshift)
    );

    // cycle j begins at rising edge j
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cyc < NC) begin
            a_stb[cyc] = {dqs_oe, dqs_o};
            a_dqe[cyc] = dq_oe;
            a_qs[cyc]  = dq_qshift;
            a_dq[cyc]  = dq_o;
            a_dm[cyc]  = dm_o;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] beat_val(input int n, input int b);
        return DW'(n * 256 + b * 16 + b + 1);
    endfunction

    // Expected data cycles for a command taken at edge k (R2, R5, R6)
    task automatic record(input int n, input int k, input logic [3:0] m);
        int c0;
        c0 = k + LAT;
        e_dat[c0]   = 1'b1;
        e_dq[c0]    = {beat_val(n, 1), beat_val(n, 0)};
        e_dm[c0]    = m[1:0];
        e_dat[c0+1] = 1'b1;
        e_dq[c0+1]  = {beat_val(n, 3), beat_val(n, 2)};
        e_dm[c0+1]  = m[3:2];
        acc_edge[n_acc] = k;
        acc_b0[n_acc]   = beat_val(n, 0);
        n_acc++;
    endtask

    task automatic issue(input int n, input int gap, input logic [3:0] m);
        repeat (gap) @(negedge clk);
        cmd_valid = 1'b1;
        for (int b = 0; b < 4; b++) cmd_data[b*DW +: DW] = beat_val(n, b);
        cmd_mask = m;
        forever begin
            bit er;
            er = (last_acc != cyc);
            check(cmd_ready === er, "R8", "cmd_ready", 64'(cmd_ready), 64'(er));
            if (er) begin
                last_acc = cyc + 1;
                record(n, cyc + 1, m);
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        if (!done && cyc > LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        int last;
        logic [3:0] es;
        string tag;
        n = 0;
        for (int c = 0; c < NC; c++) begin
            e_dat[c] = 1'b0;
            e_dq[c]  = '0;
            e_dm[c]  = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after reset
        check(cmd_ready === 1'b1, "R1", "cmd_ready", 64'(cmd_ready), 64'(1));
        check(dqs_oe === 2'b00, "R1", "dqs_oe", 64'(dqs_oe), 64'(0));
        check(dq_oe === 2'b00 && dq_qshift === 1'b0, "R1", "dq_oe/qshift",
              64'({dq_oe, dq_qshift}), 64'(0));
        check(dm_o === 2'b00, "R1", "dm_o", 64'(dm_o), 64'(0));

        // Sweep idle gap before each offer against every mask pattern;
        // gap 0 lands in the refused cycle and then continues (R9),
        // gap 1 continues directly, gap 2 merges the low cycles (R10)
        for (int g = 0; g < 6; g++) begin
            for (int m = 0; m < 16; m++) begin
                issue(n, g, 4'(m));
                n++;
            end
        end
        repeat (10) @(negedge clk);
        last = cyc;
        if (last > NC - 1) last = NC - 1;

        for (int c = 1; c < last; c++) begin
            if (e_dat[c]) begin
                es  = 4'b1101;
                tag = (c >= 2 && e_dat[c-1] && e_dat[c-2]) ? "R9" : "R4";
            end else if (e_dat[c+1]) begin
                es  = 4'b1100;
                tag = e_dat[c-1] ? "R10" : "R3";
            end else if (e_dat[c-1]) begin
                es  = 4'b0100;
                tag = "R7";
            end else begin
                es  = 4'b0000;
                tag = "R3";
            end
            check(a_stb[c] === es, tag, $sformatf("strobe {oe,lvl} cycle %0d", c),
                  64'(a_stb[c]), 64'(es));
            check(a_dqe[c] === {2{e_dat[c]}} && a_qs[c] === e_dat[c], "R11",
                  $sformatf("dq_oe/qshift cycle %0d", c),
                  64'({a_dqe[c], a_qs[c]}), 64'({{2{e_dat[c]}}, e_dat[c]}));
            check(a_dq[c] === e_dq[c], "R5", $sformatf("dq_o cycle %0d", c),
                  64'(a_dq[c]), 64'(e_dq[c]));
            check(a_dm[c] === e_dm[c], "R6", $sformatf("dm_o cycle %0d", c),
                  64'(a_dm[c]), 64'(e_dm[c]));
        end

        // R2: first beat lands WR_LAT cycles after the accepting edge
        for (int i = 0; i < n_acc; i++) begin
            int k;
            k = acc_edge[i] + LAT;
            if (k < last) begin
                check(a_dqe[k] === 2'b11 && a_dq[k][DW-1:0] === acc_b0[i], "R2",
                      $sformatf("first beat cycle %0d", k),
                      64'({a_dqe[k], a_dq[k][DW-1:0]}), 64'({2'b11, acc_b0[i]}));
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule